// File: doc/BRIEF.md
# Set-Dueling Replacement Policy Selector

This block picks which of two cache replacement policies the main cache should run. It does this by keeping shadow copies of a fixed group of cache sets. For each of these sampled sets it holds two small directories of partial tags, one per candidate policy. Each directory is filled by its own policy's victim choice. That choice arrives from outside as a way index on every access.

Each access gives a set index and a full tag. If the set is sampled, both shadow directories are looked up, and one cycle later the block reports whether each policy would have hit. A saturating counter moves one step toward the policy that hit whenever exactly one of them hit. Its most significant bit is the policy choice that every unsampled set of the main cache follows. The main tag array and the data storage lie outside this block.

Top module: `setduel_selector`

## Requirements
- R1: A set index is sampled when its bits [4:0] equal its bits [9:5]. This gives exactly 32 sampled sets out of 1024, and bits [4:0] select the shadow set. `res_sampled` reports this one cycle after the access.
- R2: `res_valid` is high in the cycle after a cycle with `acc_valid` high, and low otherwise. The `res_*` fields describe that access.
- R3: The stored partial tag is 16 bits: bits [15:0] of the 20-bit tag XOR the tag's bits [19:16] placed at partial-tag bits [3:0]. Two tags with the same partial tag are treated as the same line.
- R4: A policy hits when its shadow set holds a valid way whose partial tag equals the access's partial tag.
- R5: On a miss in a sampled set, a policy writes the partial tag into the way named by its own 4-bit victim input and marks that way valid. The other ways are left unchanged, and a hit changes nothing.
- R6: The two policies have independent directories. A fill by one policy never changes the other policy's hit result.
- R7: The 10-bit counter `sel_count` resets to 512. It rises by one when policy 0 misses and policy 1 hits, and falls by one in the opposite case. The new value shows in the same cycle as the result.
- R8: The counter saturates at 1023 and at 0.
- R9: The counter holds when both policies agree, when the set is not sampled, or when no access is made.
- R10: `policy_sel` equals bit 9 of the counter: 1 selects policy 1 and 0 selects policy 0. After reset it is 1, and `res_valid` is 0.
- R11: An access to an unsampled set reports no hits and leaves both directories unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | 10 | Set index of the access |
| acc_tag | input | 20 | Full address tag of the access |
| victim0 | input | 4 | Way to fill in policy 0's shadow set on a miss |
| victim1 | input | 4 | Way to fill in policy 1's shadow set on a miss |
| res_valid | output | 1 | Result of the previous cycle's access is present |
| res_sampled | output | 1 | That access fell in a sampled set |
| res_hit0 | output | 1 | Policy 0 shadow directory hit |
| res_hit1 | output | 1 | Policy 1 shadow directory hit |
| sel_count | output | 10 | Saturating policy selector counter |
| policy_sel | output | 1 | Policy chosen for unsampled sets |

## Verification
The assertions assume that reset is held low for at least one clock edge before any access. They also assume that `acc_valid`, the set index and the victim inputs are known whenever an access is made. The stimulus follows both rules: it holds reset for several cycles and then drives every input from known values. The victim indexes come from a 4-bit range, so they always name a real way. Random accesses mix sampled and unsampled sets with a small tag pool, which produces hits, agreements and disagreements. Two directed traces make one policy thrash while the other keeps its lines, and they drive the counter into each of its limits.

// File: rtl/setduel_pkg.sv
// Shared types for the set-dueling selector.
// Assumes nothing beyond the parameters given to the modules that use it.
package setduel_pkg;

    // Direction the selector counter moves in one cycle.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } cnt_dir_e;

endpackage

// File: rtl/setduel_sample_map.sv
// Decides whether a set index belongs to the sampled group and gives its
// shadow slot. Assumes SET_W >= 2*SLOT_W; bits above 2*SLOT_W are ignored.
module setduel_sample_map #(
    parameter int SET_W  = 10,
    parameter int SLOT_W = 5
) (
    input  logic [SET_W-1:0]  set_idx,
    output logic              is_sampled,
    output logic [SLOT_W-1:0] slot
);

    logic [SLOT_W-1:0] low_bits;
    logic [SLOT_W-1:0] high_bits;

    // Compare the low index field with the field just above it.
    always_comb begin
        low_bits   = set_idx[SLOT_W-1:0];
        high_bits  = set_idx[2*SLOT_W-1:SLOT_W];
        is_sampled = (low_bits == high_bits);
        slot       = low_bits;
    end

    if (SET_W > 2*SLOT_W) begin : g_spare_bits
        logic spare_unused;
        // Upper index bits take no part in sampling.
        assign spare_unused = ^set_idx[SET_W-1:2*SLOT_W];
    end

endmodule

// File: rtl/setduel_tag_fold.sv
// Folds a full address tag into a partial tag. Bits above PTAG_W are XORed
// into the low bits of the partial tag. Assumes TAG_W - PTAG_W <= PTAG_W.
module setduel_tag_fold #(
    parameter int TAG_W  = 20,
    parameter int PTAG_W = 16
) (
    input  logic [TAG_W-1:0]  full_tag,
    output logic [PTAG_W-1:0] part_tag
);

    localparam int EXTRA_W = TAG_W - PTAG_W;

    if (EXTRA_W > 0) begin : g_fold
        // XOR the upper tag bits onto the bottom of the partial tag.
        always_comb begin
            part_tag = full_tag[PTAG_W-1:0];
            part_tag[EXTRA_W-1:0] = part_tag[EXTRA_W-1:0] ^ full_tag[TAG_W-1:PTAG_W];
        end
    end else begin : g_pass
        // Tag already fits; pass it straight through.
        always_comb part_tag = full_tag[PTAG_W-1:0];
    end

endmodule

// File: rtl/setduel_shadow_dir.sv
// One policy's shadow directory: SLOTS sets of WAYS partial tags with valid
// bits. The lookup is combinational. On a miss while fill_en is high, the
// tag is written into the way given by the victim input.
// Assumes the victim index is below WAYS.
module setduel_shadow_dir #(
    parameter int SLOTS  = 32,
    parameter int WAYS   = 16,
    parameter int PTAG_W = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PTAG_W-1:0] ptag,
    input  logic [WAY_W-1:0]  victim,
    output logic              hit
);

    logic [WAYS-1:0]   valid_q [SLOTS];
    logic [PTAG_W-1:0] tag_q   [SLOTS][WAYS];
    logic [WAYS-1:0]   match;

    // Compare every way of the addressed slot with the incoming tag.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_q[slot][w] && (tag_q[slot][w] == ptag);
        end
        hit = |match;
    end

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (fill_en && !hit) begin
            valid_q[slot][victim] <= 1'b1;
        end
    end

    // Tag storage: written only on a fill, so it needs no reset.
    always_ff @(posedge clk) begin
        if (fill_en && !hit) begin
            tag_q[slot][victim] <= ptag;
        end
    end

endmodule

// File: rtl/setduel_sel_counter.sv
// Saturating up/down counter that records which policy is doing better.
// Resets to mid-scale. Assumes one step per cycle at most.
module setduel_sel_counter
    import setduel_pkg::*;
#(
    parameter int CNT_W = 10,
    localparam logic [CNT_W-1:0] CNT_MAX = '1,
    localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_dir_e         dir,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    // Step toward the better policy, clamping at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_MID;
        end else begin
            case (dir)
                DIR_UP:   if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
                DIR_DOWN: if (count_q != '0)      count_q <= count_q - 1'b1;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

endmodule

// File: rtl/setduel_selector.sv
// Top of the set-dueling selector. It maps the access to a shadow slot,
// looks up both policy directories, registers the hit results and steers
// the selector counter. Assumes at most one access per cycle.
module setduel_selector
    import setduel_pkg::*;
#(
    parameter int SET_W  = 10,
    parameter int TAG_W  = 20,
    parameter int PTAG_W = 16,
    parameter int SLOTS  = 32,
    parameter int WAYS   = 16,
    parameter int CNT_W  = 10,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int NPOL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [WAY_W-1:0]  victim0,
    input  logic [WAY_W-1:0]  victim1,
    output logic              res_valid,
    output logic              res_sampled,
    output logic              res_hit0,
    output logic              res_hit1,
    output logic [CNT_W-1:0]  sel_count,
    output logic              policy_sel
);

    logic              sampled;
    logic [SLOT_W-1:0] slot;
    logic [PTAG_W-1:0] ptag;
    logic              look_en;
    logic [NPOL-1:0]   pol_hit;
    logic [WAY_W-1:0]  pol_victim [NPOL];
    cnt_dir_e          dir;

    setduel_sample_map #(.SET_W(SET_W), .SLOT_W(SLOT_W)) i_map (
        .set_idx    (acc_set),
        .is_sampled (sampled),
        .slot       (slot)
    );

    setduel_tag_fold #(.TAG_W(TAG_W), .PTAG_W(PTAG_W)) i_fold (
        .full_tag (acc_tag),
        .part_tag (ptag)
    );

    // A lookup counts only for a valid access to a sampled set.
    assign look_en       = acc_valid && sampled;
    assign pol_victim[0] = victim0;
    assign pol_victim[1] = victim1;

    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        setduel_shadow_dir #(.SLOTS(SLOTS), .WAYS(WAYS), .PTAG_W(PTAG_W)) i_dir (
            .clk     (clk),
            .rst_n   (rst_n),
            .fill_en (look_en),
            .slot    (slot),
            .ptag    (ptag),
            .victim  (pol_victim[p]),
            .hit     (pol_hit[p])
        );
    end

    // Move the counter only when exactly one policy hits.
    always_comb begin
        dir = DIR_HOLD;
        if (look_en) begin
            if (!pol_hit[0] && pol_hit[1])      dir = DIR_UP;
            else if (pol_hit[0] && !pol_hit[1]) dir = DIR_DOWN;
        end
    end

    setduel_sel_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .dir   (dir),
        .count (sel_count)
    );

    // Register the per-access result one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_sampled <= 1'b0;
            res_hit0    <= 1'b0;
            res_hit1    <= 1'b0;
        end else begin
            res_valid   <= acc_valid;
            res_sampled <= look_en;
            res_hit0    <= look_en && pol_hit[0];
            res_hit1    <= look_en && pol_hit[1];
        end
    end

    assign policy_sel = sel_count[CNT_W-1];

endmodule

// File: rtl/setduel_checker.sv
// Temporal checks on the selector's ports. It is bound into every instance
// of the top. Assumes reset is low for at least one clock edge before use.
module setduel_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             res_valid,
    input logic             res_sampled,
    input logic             res_hit0,
    input logic             res_hit1,
    input logic [CNT_W-1:0] sel_count
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    // Result strobe follows the access strobe by one cycle.
    assert_res_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    assert_res_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // Unsampled results report no hit.
    assert_no_hit_unsampled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_sampled) |-> (!res_hit0 && !res_hit1));

    // Counter moves by at most one per cycle.
    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_count == $past(sel_count) ||
                  sel_count == $past(sel_count) + 1'b1 ||
                  sel_count == $past(sel_count) - 1'b1));

    // Counter holds when the policies agree or nothing counts.
    assert_hold_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid || !res_sampled || (res_hit0 == res_hit1))
            |-> (sel_count == $past(sel_count)));

    // Policy 1 alone hit: counter rises unless already at the top.
    assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sampled && !res_hit0 && res_hit1 && $past(sel_count) != CMAX)
            |-> (sel_count == $past(sel_count) + 1'b1));

    // At the top, a further rise leaves it there.
    assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sampled && !res_hit0 && res_hit1 && $past(sel_count) == CMAX)
            |-> (sel_count == CMAX));

    // At the bottom, a further fall leaves it there.
    assert_sat_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sampled && res_hit0 && !res_hit1 && $past(sel_count) == '0)
            |-> (sel_count == '0));

endmodule

bind setduel_selector setduel_checker #(.CNT_W(CNT_W)) i_setduel_checker (.*);

// File: tb/test_setduel_selector.sv
// Self-checking bench for the set-dueling selector with a reference model.
module test_setduel_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [9:0]  acc_set = '0;
    logic [19:0] acc_tag = '0;
    logic [3:0]  victim0 = '0;
    logic [3:0]  victim1 = '0;
    logic        res_valid, res_sampled, res_hit0, res_hit1, policy_sel;
    logic [9:0]  sel_count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Reference state
    bit          m_valid [2][32][16];
    logic [15:0] m_tag   [2][32][16];
    int          m_cnt;

    setduel_selector i_setduel_selector (.*);

    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [19:0] t);
        logic [15:0] r = t[15:0];
        r[3:0] = r[3:0] ^ t[19:16];
        return r;
    endfunction

    function automatic bit is_samp(input logic [9:0] s);
        return s[4:0] == s[9:5];
    endfunction

    function automatic bit m_look(input int p, input logic [9:0] s, input logic [19:0] t);
        for (int w = 0; w < 16; w++)
            if (m_valid[p][s[4:0]][w] && m_tag[p][s[4:0]][w] == fold(t)) return 1'b1;
        return 1'b0;
    endfunction

    // One access: drive at negedge, check at the following negedge.
    task automatic access(input logic [9:0] s, input logic [19:0] t,
                          input logic [3:0] w0, input logic [3:0] w1);
        bit samp, h0, h1;
        samp = is_samp(s);
        h0 = samp && m_look(0, s, t);
        h1 = samp && m_look(1, s, t);
        if (samp && !h0) begin m_valid[0][s[4:0]][w0] = 1; m_tag[0][s[4:0]][w0] = fold(t); end
        if (samp && !h1) begin m_valid[1][s[4:0]][w1] = 1; m_tag[1][s[4:0]][w1] = fold(t); end
        if (samp && !h0 && h1 && m_cnt < 1023) m_cnt++;
        if (samp && h0 && !h1 && m_cnt > 0) m_cnt--;
        acc_valid = 1; acc_set = s; acc_tag = t; victim0 = w0; victim1 = w1;
        @(negedge clk);
        acc_valid = 0;
        chk(res_valid == 1, "R2 res_valid", res_valid, 1);
        chk(res_sampled == samp, "R1 sampled", res_sampled, samp);
        chk(res_hit0 == h0, "R4 hit0", res_hit0, h0);
        chk(res_hit1 == h1, "R6 hit1", res_hit1, h1);
        chk(sel_count == m_cnt, "R7 count", sel_count, m_cnt);
        chk(policy_sel == (m_cnt >= 512), "R10 policy_sel", policy_sel, m_cnt >= 512);
    endtask

    task automatic idle();
        @(negedge clk);
        chk(res_valid == 0, "R2 idle res_valid", res_valid, 0);
        chk(sel_count == m_cnt, "R9 idle count", sel_count, m_cnt);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_cnt = 512;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(sel_count == 512, "R7 reset count", sel_count, 512);
        chk(policy_sel == 1, "R10 reset policy_sel", policy_sel, 1);
        chk(res_valid == 0, "R10 reset res_valid", res_valid, 0);

        // R5/R11: fill slot 3 way 0, unsampled access to same slot must not clobber
        access({5'd3, 5'd3}, 20'h0_0AAA, 4'd0, 4'd0);
        access({5'd5, 5'd3}, 20'h0_0BBB, 4'd0, 4'd0);
        access({5'd3, 5'd3}, 20'h0_0AAA, 4'd1, 4'd1);
        // R3: alias through the fold (0x1_2345 -> 0x2344)
        access({5'd9, 5'd9}, 20'h1_2345, 4'd2, 4'd2);
        access({5'd9, 5'd9}, 20'h0_2344, 4'd3, 4'd3);
        chk(res_hit0 && res_hit1, "R3 alias hit", res_hit0 + res_hit1, 2);
        idle();

        // R8: policy 0 thrashes way 0, policy 1 keeps both lines -> top
        for (int i = 0; i < 600; i++)
            access({5'd7, 5'd7}, (i % 2) ? 20'h0_2222 : 20'h0_1111,
                   4'd0, (i % 2) ? 4'd2 : 4'd1);
        chk(sel_count == 1023, "R8 saturate high", sel_count, 1023);

        // R8: roles swapped with fresh tags -> bottom
        for (int i = 0; i < 1100; i++)
            access({5'd7, 5'd7}, (i % 2) ? 20'h0_4444 : 20'h0_3333,
                   (i % 2) ? 4'd4 : 4'd3, 4'd0);
        chk(sel_count == 0, "R8 saturate low", sel_count, 0);
        chk(policy_sel == 0, "R10 low policy_sel", policy_sel, 0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  sl = 5'($urandom % 32);
            logic [9:0]  s  = ($urandom % 2) ? {sl, sl} : 10'($urandom);
            logic [19:0] t  = {4'($urandom % 2), 13'd0, 3'($urandom % 8)};
            if ($urandom % 8 == 0) idle();
            else access(s, t, 4'($urandom), 4'($urandom));
        end
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule